// File: doc/BRIEF.md
# I2C-Mapped GPIO Register Bank

This block is a target on a two-wire I2C bus. It gives a host byte-wide access to one control register per general-purpose pin, plus two serial-channel routing selectors and a PWM routing flag. The target answers to a window of eight consecutive 7-bit bus addresses. A write carries a 16-bit register pointer, high byte first, and then data bytes. A read sets the pointer the same way, then issues a repeated START with the read bit set. The pointer steps forward after every data byte, so a burst reaches consecutive registers.

Each pin register holds two stored bits: the drive enable in bit 0 and the drive value in bit 1. Bit 2 returns the live pin level after a two-flop synchronizer. The upper bits are zero. SCL and SDA are sampled with the system clock through synchronizers. SDA is driven open-drain through an output-enable signal that pulls the line low. The target never stretches the clock.

Top module: `i2c_gpio_bank`

## Requirements
- R1: The target acknowledges a bus address whose upper four bits equal those of 0x28, which means any address from 0x28 to 0x2F. Any other address gets no acknowledge: SDA stays high during the ninth clock, and no register changes.
- R2: In a write, the first two bytes after the address load the register pointer, most significant byte first. Each later byte is written to the register at the pointer. The target acknowledges every byte.
- R3: For a pin register n (0 to NUM_PINS-1), bit 0 drives `gpio_oe[n]` and bit 1 drives `gpio_out[n]`. Written bits 7:3 are discarded, and they read back as 0.
- R4: A read uses a pointer write followed by a repeated START with the read bit set (address byte LSB = 1). It returns the register at the pointer, MSB first. Bit 2 of a pin register is the level of `gpio_in[n]` after synchronization.
- R5: The pointer increments after every data byte, whether read or written. A multi-byte burst therefore accesses consecutive registers. A read burst continues while the host acknowledges and ends on a not-acknowledge.
- R6: Register 307 bits 2:0 drive `uart_sel_a`, and register 308 bits 2:0 drive `uart_sel_b`. The other bits of both registers are dropped and read as 0.
- R7: Register 309 bit 0 drives `pwm_route`. It reads back in bit 0, and the other bits read as 0.
- R8: An address outside the mapped registers reads as 0x00. A write to it changes no output.
- R9: A STOP returns the target to idle from any point, releases SDA, and abandons a partly received data byte without writing it. The next transfer then works normally.
- R10: The target changes its SDA drive only while SCL is low.
- R11: After reset, all pin enables and values, both selectors and the PWM flag are 0, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Level of the SCL bus line |
| sda_i | input | 1 | Level of the SDA bus line |
| sda_oe | output | 1 | Pull SDA low when 1 |
| gpio_in | input | NUM_PINS | Pin input levels, asynchronous |
| gpio_out | output | NUM_PINS | Pin drive values |
| gpio_oe | output | NUM_PINS | Pin drive enables |
| uart_sel_a | output | 3 | First serial routing selector |
| uart_sel_b | output | 3 | Second serial routing selector |
| pwm_route | output | 1 | Route processor PWM to first digital pin |

## Verification
A pointer that is off by one is visible on the very next data byte. It lands on a neighbouring pin's enable or value output, or it returns that neighbour's byte in a read burst. A byte-phase or bit-count error shows within one byte time in one of three ways:
- a missing or misplaced acknowledge,
- a bit shifted into the wrong position of a read byte,
- a pin changing after a STOP that should have abandoned the byte.

The bus-timing assertions flag a wrong state register within the cycle it appears. Typical wrong states are SDA held after a STOP, or a drive change while SCL is high.

// File: rtl/i2cgpio_pkg.sv
package i2cgpio_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_A,
        ST_RX,
        ST_ACK_R,
        ST_TX,
        ST_ACK_T
    } tgt_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    typedef struct packed {
        logic              en;
        logic [PTR_W-1:0]  addr;
        logic [BYTE_W-1:0] data;
    } reg_wr_t;

    function automatic logic addr_hit(input logic [6:0] a, input logic [6:0] base,
                                      input int ign);
        logic [6:0] mask;
        mask = 7'h7f << ign;
        return (a & mask) == (base & mask);
    endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync
    import i2cgpio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t ev
);
    logic [2:0] scl_ff;
    logic [2:0] sda_ff;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= 3'b111;
            sda_ff <= 3'b111;
        end else begin
            scl_ff <= {scl_ff[1:0], scl_i};
            sda_ff <= {sda_ff[1:0], sda_i};
        end
    end

    always_comb begin
        ev.scl   = scl_ff[1];
        ev.sda   = sda_ff[1];
        ev.start = scl_ff[1] & scl_ff[2] & sda_ff[2] & ~sda_ff[1];
        ev.stop  = scl_ff[1] & scl_ff[2] & ~sda_ff[2] & sda_ff[1];
        ev.rise  = ~scl_ff[2] & scl_ff[1];
        ev.fall  = scl_ff[2] & ~scl_ff[1];
    end
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2cgpio_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR    = 7'h28,
    parameter int         ADDR_IGNORE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          ev,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output reg_wr_t           wr,
    output logic [PTR_W-1:0]  ptr
);
    tgt_state_e        state;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw;
    logic              mack;
    logic [1:0]        byte_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            rw       <= 1'b0;
            mack     <= 1'b0;
            byte_idx <= '0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
            wr       <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.start) begin
                state    <= ST_ADDR;
                bitcnt   <= '0;
                byte_idx <= '0;
                sda_oe   <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (ev.rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.fall && bitcnt == 4'd8) begin
                            if (addr_hit(shreg[7:1], TGT_ADDR, ADDR_IGNORE)) begin
                                sda_oe <= 1'b1;
                                rw     <= shreg[0];
                                state  <= ST_ACK_A;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK_A: begin
                        if (ev.fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                state  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_RX;
                            end
                        end
                    end
                    ST_RX: begin
                        if (ev.rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.fall && bitcnt == 4'd8) begin
                            sda_oe <= 1'b1;
                            state  <= ST_ACK_R;
                            case (byte_idx)
                                2'd0:    ptr[15:8] <= shreg;
                                2'd1:    ptr[7:0]  <= shreg;
                                default: begin
                                    wr.en   <= 1'b1;
                                    wr.addr <= ptr;
                                    wr.data <= shreg;
                                    ptr     <= ptr + 1'b1;
                                end
                            endcase
                            if (byte_idx != 2'd2) byte_idx <= byte_idx + 2'd1;
                        end
                    end
                    ST_ACK_R: begin
                        if (ev.fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_RX;
                        end
                    end
                    ST_TX: begin
                        if (ev.rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 1'b1;
                                state  <= ST_ACK_T;
                            end else if (bitcnt != 4'd0) begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_ACK_T: begin
                        if (ev.rise) begin
                            mack <= ~ev.sda;
                        end else if (ev.fall) begin
                            bitcnt <= '0;
                            if (mack) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                state  <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (ev.scl && $past(ev.scl) && !ev.stop && !ev.start) |-> $stable(sda_oe)); // R10
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (!sda_oe && state == ST_IDLE)); // R9
    AST_PTR_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (ptr == wr.addr + 1'b1)); // R5
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import i2cgpio_pkg::*;
#(
    parameter int NUM_PINS  = 44,
    parameter int SEL_A_REG = 307,
    parameter int SEL_B_REG = 308,
    parameter int PWM_REG   = 309,
    parameter int SEL_W     = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  reg_wr_t             wr,
    input  logic [PTR_W-1:0]    rd_addr,
    input  logic [NUM_PINS-1:0] gpio_in,
    output logic [NUM_PINS-1:0] gpio_out,
    output logic [NUM_PINS-1:0] gpio_oe,
    output logic [SEL_W-1:0]    uart_sel_a,
    output logic [SEL_W-1:0]    uart_sel_b,
    output logic                pwm_route,
    output logic [BYTE_W-1:0]   rd_data
);
    localparam int PIN_IDX_W = $clog2(NUM_PINS);

    logic [NUM_PINS-1:0] in_meta, in_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_meta <= '0;
            in_sync <= '0;
        end else begin
            in_meta <= gpio_in;
            in_sync <= in_meta;
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) begin
                gpio_oe[i]  <= 1'b0;
                gpio_out[i] <= 1'b0;
            end else if (wr.en && wr.addr == PTR_W'(i)) begin
                gpio_oe[i]  <= wr.data[0];
                gpio_out[i] <= wr.data[1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            uart_sel_a <= '0;
            uart_sel_b <= '0;
            pwm_route  <= 1'b0;
        end else if (wr.en) begin
            if (wr.addr == PTR_W'(SEL_A_REG)) uart_sel_a <= wr.data[SEL_W-1:0];
            if (wr.addr == PTR_W'(SEL_B_REG)) uart_sel_b <= wr.data[SEL_W-1:0];
            if (wr.addr == PTR_W'(PWM_REG))   pwm_route  <= wr.data[0];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr < PTR_W'(NUM_PINS)) begin
            rd_data[0] = gpio_oe[rd_addr[PIN_IDX_W-1:0]];
            rd_data[1] = gpio_out[rd_addr[PIN_IDX_W-1:0]];
            rd_data[2] = in_sync[rd_addr[PIN_IDX_W-1:0]];
        end else if (rd_addr == PTR_W'(SEL_A_REG)) begin
            rd_data[SEL_W-1:0] = uart_sel_a;
        end else if (rd_addr == PTR_W'(SEL_B_REG)) begin
            rd_data[SEL_W-1:0] = uart_sel_b;
        end else if (rd_addr == PTR_W'(PWM_REG)) begin
            rd_data[0] = pwm_route;
        end
    end

    logic wr_unmapped;
    assign wr_unmapped = wr.en && !(wr.addr < PTR_W'(NUM_PINS)) &&
                         wr.addr != PTR_W'(SEL_A_REG) && wr.addr != PTR_W'(SEL_B_REG) &&
                         wr.addr != PTR_W'(PWM_REG);

    AST_UNMAPPED_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        wr_unmapped |=> ($stable(gpio_oe) && $stable(gpio_out) && $stable(uart_sel_a) &&
                         $stable(uart_sel_b) && $stable(pwm_route))); // R8
endmodule

// File: rtl/i2c_gpio_bank.sv
module i2c_gpio_bank
    import i2cgpio_pkg::*;
#(
    parameter int         NUM_PINS    = 44,
    parameter logic [6:0] TGT_ADDR    = 7'h28,
    parameter int         ADDR_IGNORE = 3,
    parameter int         SEL_A_REG   = 307,
    parameter int         SEL_B_REG   = 308,
    parameter int         PWM_REG     = 309,
    parameter int         SEL_W       = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe,
    input  logic [NUM_PINS-1:0] gpio_in,
    output logic [NUM_PINS-1:0] gpio_out,
    output logic [NUM_PINS-1:0] gpio_oe,
    output logic [SEL_W-1:0]    uart_sel_a,
    output logic [SEL_W-1:0]    uart_sel_b,
    output logic                pwm_route
);
    bus_evt_t          ev;
    reg_wr_t           wr;
    logic [PTR_W-1:0]  ptr;
    logic [BYTE_W-1:0] rd_data;

    i2c_bus_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_target_fsm #(
        .TGT_ADDR    (TGT_ADDR),
        .ADDR_IGNORE (ADDR_IGNORE)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .rd_data (rd_data),
        .sda_oe  (sda_oe),
        .wr      (wr),
        .ptr     (ptr)
    );

    gpio_regbank #(
        .NUM_PINS  (NUM_PINS),
        .SEL_A_REG (SEL_A_REG),
        .SEL_B_REG (SEL_B_REG),
        .PWM_REG   (PWM_REG),
        .SEL_W     (SEL_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr),
        .rd_addr    (ptr),
        .gpio_in    (gpio_in),
        .gpio_out   (gpio_out),
        .gpio_oe    (gpio_oe),
        .uart_sel_a (uart_sel_a),
        .uart_sel_b (uart_sel_b),
        .pwm_route  (pwm_route),
        .rd_data    (rd_data)
    );
endmodule

// File: tb/tb_i2c_gpio_bank.sv
module tb_i2c_gpio_bank;
    localparam int NP = 44;
    localparam int H  = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          m_scl_low = 1'b0;
    logic          m_sda_low = 1'b0;
    logic          sda_oe;
    logic [NP-1:0] gpio_in = '0;
    logic [NP-1:0] gpio_out, gpio_oe;
    logic [2:0]    uart_sel_a, uart_sel_b;
    logic          pwm_route;

    wire scl_line = !m_scl_low;
    wire sda_line = !(m_sda_low || sda_oe);

    always #2 clk = ~clk;

    i2c_gpio_bank dut (
        .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line), .sda_oe(sda_oe),
        .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .uart_sel_a(uart_sel_a), .uart_sel_b(uart_sel_b), .pwm_route(pwm_route)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    int r10_viol = 0;

    logic [7:0]  exp_q[$];
    logic [7:0]  got_q[$];
    string       tag_q[$];

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected bytes as read bytes arrive
    initial begin
        forever begin
            wait (got_q.size() > 0);
            check(64'(got_q.pop_front()), 64'(exp_q.pop_front()), tag_q.pop_front());
        end
    end

    // R10: drive change of target while SCL held high
    logic prev_oe = 1'b0, prev_scl = 1'b1;
    always @(negedge clk) begin
        if (!rst && scl_line && prev_scl && sda_oe != prev_oe) r10_viol++;
        prev_oe  <= sda_oe;
        prev_scl <= scl_line;
    end

    task automatic hw();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; hw();
        m_scl_low = 1'b0; hw();
        m_sda_low = 1'b1; hw();
        m_scl_low = 1'b1; hw();
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; hw();
        m_scl_low = 1'b0; hw();
        m_sda_low = 1'b0; hw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = !b[i]; hw();
            m_scl_low = 1'b0;  hw();
            m_scl_low = 1'b1;
        end
        m_sda_low = 1'b0; hw();
        m_scl_low = 1'b0;
        repeat (H / 2) @(negedge clk);
        ack = !sda_line;
        repeat (H / 2) @(negedge clk);
        m_scl_low = 1'b1;
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] b);
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            hw();
            m_scl_low = 1'b0;
            repeat (H / 2) @(negedge clk);
            b[i] = sda_line;
            repeat (H / 2) @(negedge clk);
            m_scl_low = 1'b1;
        end
        m_sda_low = host_ack; hw();
        m_scl_low = 1'b0;     hw();
        m_scl_low = 1'b1;
        m_sda_low = 1'b0;
    endtask

    task automatic wr_regs(input logic [6:0] dev, input logic [15:0] addr,
                           input logic [7:0] d [4], input int n, input string tag);
        logic a;
        bus_start();
        send_byte({dev, 1'b0}, a); check(64'(a), 1, {tag, " addr ack"});
        send_byte(addr[15:8], a);  check(64'(a), 1, {tag, " ptr hi ack"});
        send_byte(addr[7:0], a);   check(64'(a), 1, {tag, " ptr lo ack"});
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], a);    check(64'(a), 1, {tag, " data ack"});
        end
        bus_stop();
    endtask

    task automatic rd_regs(input logic [15:0] addr, input logic [7:0] e [4],
                           input int n, input string tag);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'h50, a);       check(64'(a), 1, {tag, " addr ack"});
        send_byte(addr[15:8], a);
        send_byte(addr[7:0], a);
        bus_start();
        send_byte(8'h51, a);       check(64'(a), 1, {tag, " read addr ack"});
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(e[i]);
            tag_q.push_back({tag, " read byte"});
            recv_byte(i < n - 1, b);
            got_q.push_back(b);
        end
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [NP-1:0] e_oe, e_out;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R11 reset state
        check(64'(sda_oe), 0, "R11 sda released");
        check(64'(gpio_oe), 0, "R11 gpio_oe");
        check(64'(gpio_out), 0, "R11 gpio_out");
        check(64'({uart_sel_a, uart_sel_b, pwm_route}), 0, "R11 selectors");
        e_oe = '0; e_out = '0;

        // R1 R2 R3: write at low end of address window
        wr_regs(7'h28, 16'd0, '{8'h03, 0, 0, 0}, 1, "R1 R2 reg0");
        e_oe[0] = 1; e_out[0] = 1;
        check(64'(gpio_oe), 64'(e_oe), "R3 oe after reg0");
        check(64'(gpio_out), 64'(e_out), "R3 out after reg0");

        // R1 top of window, last pin
        wr_regs(7'h2F, 16'd43, '{8'h01, 0, 0, 0}, 1, "R1 addr 2F");
        e_oe[43] = 1;
        check(64'(gpio_oe), 64'(e_oe), "R1 oe after reg43");

        // R1 outside the window
        bus_start(); send_byte({7'h27, 1'b0}, a); bus_stop();
        check(64'(a), 0, "R1 no ack 0x27");
        bus_start(); send_byte({7'h30, 1'b0}, a); bus_stop();
        check(64'(a), 0, "R1 no ack 0x30");
        check(64'(gpio_oe), 64'(e_oe), "R1 outputs unchanged");

        // R5 burst write 10..12 (bit0 enable, bit1 value)
        wr_regs(7'h2C, 16'd10, '{8'h02, 8'h03, 8'h01, 0}, 3, "R5 burst");
        e_out[10] = 1; e_oe[11] = 1; e_out[11] = 1; e_oe[12] = 1;
        check(64'(gpio_oe), 64'(e_oe), "R5 burst oe");
        check(64'(gpio_out), 64'(e_out), "R5 burst out");

        // R3 reserved bits dropped
        wr_regs(7'h28, 16'd5, '{8'hFF, 0, 0, 0}, 1, "R3 reg5");
        e_oe[5] = 1; e_out[5] = 1;
        rd_regs(16'd5, '{8'h03, 0, 0, 0}, 1, "R3 reg5 readback");

        // R4 R5 input bit and read burst
        gpio_in = '0;
        gpio_in[36] = 1; gpio_in[38] = 1;
        repeat (10) @(negedge clk);
        rd_regs(16'd36, '{8'h04, 8'h00, 8'h04, 0}, 3, "R4 R5 input burst");
        rd_regs(16'd10, '{8'h02, 8'h03, 8'h01, 0}, 3, "R5 read burst");
        gpio_in[10] = 1;
        repeat (10) @(negedge clk);
        rd_regs(16'd10, '{8'h06, 0, 0, 0}, 1, "R4 input with drive");

        // R6 selectors
        wr_regs(7'h28, 16'd307, '{8'h05, 8'hFE, 0, 0}, 2, "R6 sel write");
        check(64'(uart_sel_a), 5, "R6 sel_a");
        check(64'(uart_sel_b), 6, "R6 sel_b");
        rd_regs(16'd307, '{8'h05, 8'h06, 0, 0}, 2, "R6 sel readback");

        // R7 PWM route
        wr_regs(7'h28, 16'd309, '{8'h01, 0, 0, 0}, 1, "R7 set");
        check(64'(pwm_route), 1, "R7 pwm set");
        rd_regs(16'd309, '{8'h01, 0, 0, 0}, 1, "R7 readback");
        wr_regs(7'h28, 16'd309, '{8'hFE, 0, 0, 0}, 1, "R7 clear");
        check(64'(pwm_route), 0, "R7 pwm clear");

        // R8 unmapped
        wr_regs(7'h28, 16'd200, '{8'hFF, 8'hFF, 0, 0}, 2, "R8 write");
        check(64'(gpio_oe), 64'(e_oe), "R8 oe unchanged");
        check(64'(gpio_out), 64'(e_out), "R8 out unchanged");
        check(64'({uart_sel_a, uart_sel_b, pwm_route}), 64'({3'd5, 3'd6, 1'b0}),
              "R8 selectors unchanged");
        rd_regs(16'd200, '{8'h00, 0, 0, 0}, 1, "R8 read 200");
        rd_regs(16'd44, '{8'h00, 0, 0, 0}, 1, "R8 read 44");

        // R9 stop mid data byte abandons it
        bus_start();
        send_byte(8'h50, a); send_byte(8'h00, a); send_byte(8'd2, a);
        for (int i = 0; i < 3; i++) begin
            m_sda_low = 1'b0; hw();
            m_scl_low = 1'b0; hw();
            m_scl_low = 1'b1;
        end
        bus_stop();
        check(64'(gpio_oe[2]), 0, "R9 partial byte dropped");
        check(64'(sda_oe), 0, "R9 sda released");
        wr_regs(7'h28, 16'd2, '{8'h01, 0, 0, 0}, 1, "R9 after stop");
        e_oe[2] = 1;
        check(64'(gpio_oe), 64'(e_oe), "R9 later write works");

        check(64'(r10_viol), 0, "R10 no drive change with SCL high");

        wait (got_q.size() == 0);
        repeat (5) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule